// File: doc/BRIEF.md
# Ring Buffer Occupancy and Threshold Interrupt Unit

This block keeps the bookkeeping for one circular byte buffer that a peripheral-side transfer engine and software share. It serves one direction at a time. In receive mode the hardware fills the ring and software drains it. In transmit mode software fills the ring and the hardware drains it. The block holds a write pointer and a read pointer. Each pointer has a byte offset with a wrap flag just above it. The pointer owned by software is loaded or advanced through register-style strobes. The pointer owned by the hardware moves one byte per step strobe.

From the two pointers the block derives two counts in combinational logic. The first is the filled count: bytes waiting for the consumer. The second is the free count: bytes the producer may still write. The ring length is a power of two, chosen by its base-two logarithm. A full ring and an empty ring have the same offsets, so the block tells them apart by the wrap flags and keeps no separate counter.

The block also holds two sticky interrupt flags. The level flag records that the count watched for the current direction has reached a programmed threshold. The full flag records, in receive mode only, that no free space is left. A single level interrupt line is the OR of the flags that are enabled.

Top module: `rbq_ring_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers, both flags and `irq` are cleared. The filled count then reads 0 and the free count reads the ring length.
- R2: Pointer bit OFF_W is the wrap flag and the bits below it are the offset. The filled count is (write offset + length - read offset) when the two wrap flags differ, and (write offset - read offset) when they match. The free count is length minus the filled count. Both counts follow any pointer change in the same cycle.
- R3: A hardware step is ignored when the free count is zero in receive mode (producer) or when the filled count is zero in transmit mode (consumer). The ring therefore never overflows or underflows.
- R4: When a pointer advances by n and the masked offset + n is at least the length, the new offset is (offset + n) masked with length-1 and the wrap flag inverts. Otherwise the offset becomes offset + n and the wrap flag is kept.
- R5: A software advance by n moves the software-owned pointer by the smaller of n and the available count. The available count is the free count in transmit mode and the filled count in receive mode.
- R6: A software load (`cfg_rx`=1 moves the read pointer, `cfg_rx`=0 moves the write pointer) stores the given wrap flag and the offset masked with length-1. A load takes priority over an advance in the same cycle. The other pointer is not affected.
- R7: Flag bit 0 is set at a clock edge when, before that edge, the filled count is at least the threshold (receive) or the free count is at least the threshold (transmit).
- R8: Flag bit 1 is set at a clock edge when, before that edge, the ring is full in receive mode. It is never set in transmit mode.
- R9: The flags stay set until cleared. A 1 on bit i of `flag_clr` clears flag i, unless that flag's set condition holds in the same cycle, in which case the flag stays set.
- R10: `irq` is high exactly when some flag bit i is set and `irq_en` bit i is 1.
- R11: In receive mode the hardware step moves the write pointer and software moves the read pointer. In transmit mode the roles are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx | input | 1 | 1 = receive ring, 0 = transmit ring |
| cfg_len_log2 | input | LOG_W | Ring length is 2 to this power; values above OFF_W act as OFF_W |
| cfg_thresh | input | OFF_W+1 | Interrupt threshold in bytes |
| irq_en | input | 2 | Per-flag interrupt enables |
| sw_load | input | 1 | Load the software-owned pointer |
| sw_load_ptr | input | OFF_W+1 | Pointer value to load (wrap flag in the top bit) |
| sw_adv | input | 1 | Advance the software-owned pointer |
| sw_adv_cnt | input | OFF_W+1 | Bytes to advance by (clamped) |
| hw_step | input | 1 | One-byte step of the hardware-owned pointer |
| flag_clr | input | 2 | Write-one-to-clear for the flags |
| wr_ptr | output | OFF_W+1 | Write pointer |
| rd_ptr | output | OFF_W+1 | Read pointer |
| valid_cnt | output | OFF_W+1 | Filled byte count |
| left_cnt | output | OFF_W+1 | Free byte count |
| irq_flags | output | 2 | Sticky flags: bit 0 level, bit 1 full |
| irq_flags | output | 2 | Sticky flags: bit 0 level, bit 1 full |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the ring length and direction stay fixed between resets. They also assume that every software load leaves the filled count between zero and the length, so the occupancy arithmetic never goes negative. The stimulus respects both assumptions. It resets the block before each change of length or direction. In receive mode it loads the read pointer only to the current write pointer position. In transmit mode it loads the write pointer only a small distance ahead of the read pointer. Advances that ask for more than the available count are applied on purpose, because clamping them is part of the required behaviour.

// File: rtl/rbq_pkg.sv
package rbq_pkg;

    // Arithmetic width used by the shared helper functions.
    localparam int unsigned RBQ_CALC_W = 32;

    localparam int unsigned RBQ_FLAG_LEVEL = 0;
    localparam int unsigned RBQ_FLAG_FULL  = 1;
    localparam int unsigned RBQ_NFLAGS     = 2;

    typedef logic [RBQ_CALC_W-1:0] rbq_word_t;

    typedef enum logic {
        RBQ_DIR_TX = 1'b0,
        RBQ_DIR_RX = 1'b1
    } rbq_dir_e;

    typedef struct packed {
        logic      wrap;
        rbq_word_t off;
    } rbq_pos_t;

    // Move a position forward by cnt bytes on a ring of length len (power of two).
    function automatic rbq_pos_t rbq_advance(input rbq_pos_t cur, input rbq_word_t cnt,
                                             input rbq_word_t len);
        rbq_word_t mask;
        rbq_word_t sum;
        rbq_pos_t  nxt;
        mask = len - rbq_word_t'(1);
        sum  = (cur.off & mask) + cnt;
        if (sum >= len) begin
            nxt.wrap = ~cur.wrap;
            nxt.off  = sum & mask;
        end else begin
            nxt.wrap = cur.wrap;
            nxt.off  = sum;
        end
        return nxt;
    endfunction

    // Bytes between read and write positions, wrap flags deciding full vs empty.
    function automatic rbq_word_t rbq_occupancy(input rbq_pos_t wr, input rbq_pos_t rd,
                                                input rbq_word_t len);
        rbq_word_t occ;
        if (wr.wrap != rd.wrap) occ = wr.off + len - rd.off;
        else                    occ = wr.off - rd.off;
        return occ;
    endfunction

endpackage

// File: rtl/rbq_ptr.sv
module rbq_ptr
    import rbq_pkg::*;
#(
    parameter int unsigned OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OFF_W:0]   load_val,
    input  logic             adv,
    input  logic [OFF_W:0]   adv_cnt,
    input  logic [OFF_W:0]   ring_len,
    output logic [OFF_W:0]   ptr
);

    localparam int unsigned PAD = RBQ_CALC_W - OFF_W - 1;

    logic [OFF_W-1:0] mask;
    logic [OFF_W:0]   ptr_q;
    logic [OFF_W:0]   ptr_d;
    rbq_pos_t         cur_pos;
    rbq_pos_t         adv_pos;
    rbq_word_t        cnt_w;
    rbq_word_t        len_w;

    assign mask  = ring_len[OFF_W-1:0] - OFF_W'(1);
    assign cnt_w = {{PAD{1'b0}}, adv_cnt};
    assign len_w = {{PAD{1'b0}}, ring_len};

    always_comb begin
        cur_pos.wrap = ptr_q[OFF_W];
        cur_pos.off  = {{(PAD+1){1'b0}}, ptr_q[OFF_W-1:0]};
        adv_pos      = rbq_advance(cur_pos, cnt_w, len_w);
    end

    always_comb begin
        if (load)     ptr_d = {load_val[OFF_W], load_val[OFF_W-1:0] & mask};
        else if (adv) ptr_d = {adv_pos.wrap, adv_pos.off[OFF_W-1:0]};
        else          ptr_d = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // Independent sum used only by the wrap checks below.
    logic [OFF_W+1:0] sum_chk;
    assign sum_chk = {2'b00, ptr_q[OFF_W-1:0] & mask} + {1'b0, adv_cnt};

    // R4: crossing the ring end inverts the wrap flag
    a_r4_wrap_toggle: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && (sum_chk >= {1'b0, ring_len})) |=> (ptr_q[OFF_W] != $past(ptr_q[OFF_W])));

    // R4: staying inside the ring keeps the wrap flag
    a_r4_wrap_keep: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && (sum_chk < {1'b0, ring_len})) |=> $stable(ptr_q[OFF_W]));

endmodule

// File: rtl/rbq_level.sv
module rbq_level
    import rbq_pkg::*;
#(
    parameter int unsigned OFF_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OFF_W:0] wr_ptr,
    input  logic [OFF_W:0] rd_ptr,
    input  logic [OFF_W:0] ring_len,
    output logic [OFF_W:0] valid_cnt,
    output logic [OFF_W:0] left_cnt
);

    localparam int unsigned PAD = RBQ_CALC_W - OFF_W;

    rbq_pos_t  wr_pos;
    rbq_pos_t  rd_pos;
    rbq_word_t occ;

    always_comb begin
        wr_pos.wrap = wr_ptr[OFF_W];
        wr_pos.off  = {{PAD{1'b0}}, wr_ptr[OFF_W-1:0]};
        rd_pos.wrap = rd_ptr[OFF_W];
        rd_pos.off  = {{PAD{1'b0}}, rd_ptr[OFF_W-1:0]};
        occ         = rbq_occupancy(wr_pos, rd_pos, {{(PAD-1){1'b0}}, ring_len});
    end

    assign valid_cnt = occ[OFF_W:0];
    assign left_cnt  = ring_len - valid_cnt;

    // R2: registered pointers never describe more bytes than the ring holds
    a_r2_valid_bounded: assert property (@(posedge clk) disable iff (rst)
        valid_cnt <= ring_len);

endmodule

// File: rtl/rbq_irq.sv
module rbq_irq
    import rbq_pkg::*;
#(
    parameter int unsigned OFF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  rbq_dir_e              dir,
    input  logic [OFF_W:0]        valid_cnt,
    input  logic [OFF_W:0]        left_cnt,
    input  logic [OFF_W:0]        thresh,
    input  logic [RBQ_NFLAGS-1:0] en,
    input  logic [RBQ_NFLAGS-1:0] clr,
    output logic [RBQ_NFLAGS-1:0] flags,
    output logic                  irq
);

    logic [RBQ_NFLAGS-1:0] cond;
    logic [RBQ_NFLAGS-1:0] flags_q;

    always_comb begin
        cond = '0;
        if (dir == RBQ_DIR_RX) begin
            cond[RBQ_FLAG_LEVEL] = (valid_cnt >= thresh);
            cond[RBQ_FLAG_FULL]  = (left_cnt == '0);
        end else begin
            cond[RBQ_FLAG_LEVEL] = (left_cnt >= thresh);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr) | cond;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en);

    // R7: a met threshold is recorded at the next edge
    a_r7_level_sets: assert property (@(posedge clk) disable iff (rst)
        cond[RBQ_FLAG_LEVEL] |=> flags_q[RBQ_FLAG_LEVEL]);

    // R9: a clear without a pending set empties the flag
    a_r9_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr[RBQ_FLAG_LEVEL] && !cond[RBQ_FLAG_LEVEL]) |=> !flags_q[RBQ_FLAG_LEVEL]);

    // R8: the full flag only ever rises while receiving
    a_r8_full_rx_only: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[RBQ_FLAG_FULL]) |-> ($past(dir) == RBQ_DIR_RX));

endmodule

// File: rtl/rbq_ring_monitor.sv
module rbq_ring_monitor
    import rbq_pkg::*;
#(
    parameter int unsigned OFF_W = 16,
    parameter int unsigned LOG_W = $clog2(OFF_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_rx,
    input  logic [LOG_W-1:0]      cfg_len_log2,
    input  logic [OFF_W:0]        cfg_thresh,
    input  logic [1:0]            irq_en,
    input  logic                  sw_load,
    input  logic [OFF_W:0]        sw_load_ptr,
    input  logic                  sw_adv,
    input  logic [OFF_W:0]        sw_adv_cnt,
    input  logic                  hw_step,
    input  logic [1:0]            flag_clr,
    output logic [OFF_W:0]        wr_ptr,
    output logic [OFF_W:0]        rd_ptr,
    output logic [OFF_W:0]        valid_cnt,
    output logic [OFF_W:0]        left_cnt,
    output logic [1:0]            irq_flags,
    output logic                  irq
);

    localparam logic [LOG_W-1:0] MAX_K   = LOG_W'(OFF_W);
    localparam logic [OFF_W:0]   ONE_CNT = (OFF_W+1)'(1);
    localparam int unsigned      NPTR    = 2;   // index 0 write, index 1 read

    rbq_dir_e           dir;
    logic [LOG_W-1:0]   k_eff;
    logic [OFF_W:0]     ring_len;
    logic [OFF_W:0]     sw_avail;
    logic [OFF_W:0]     sw_cnt;
    logic               hw_ok;

    logic [NPTR-1:0]            p_load;
    logic [NPTR-1:0]            p_adv;
    logic [NPTR-1:0][OFF_W:0]   p_cnt;
    logic [NPTR-1:0][OFF_W:0]   p_q;

    assign dir      = rbq_dir_e'(cfg_rx);
    assign k_eff    = (cfg_len_log2 > MAX_K) ? MAX_K : cfg_len_log2;
    assign ring_len = ONE_CNT << k_eff;

    // Software side is clamped to what its partner has made available.
    assign sw_avail = (dir == RBQ_DIR_RX) ? valid_cnt : left_cnt;
    assign sw_cnt   = (sw_adv_cnt > sw_avail) ? sw_avail : sw_adv_cnt;

    // Hardware step is dropped when it would overrun the other pointer.
    assign hw_ok = hw_step & ((dir == RBQ_DIR_RX) ? (left_cnt != '0) : (valid_cnt != '0));

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic sw_owned;
        if (g == 0) begin : g_wr
            assign sw_owned = (dir == RBQ_DIR_TX);
        end else begin : g_rd
            assign sw_owned = (dir == RBQ_DIR_RX);
        end

        assign p_load[g] = sw_owned & sw_load;
        assign p_adv[g]  = sw_owned ? sw_adv : hw_ok;
        assign p_cnt[g]  = sw_owned ? sw_cnt : ONE_CNT;

        rbq_ptr #(.OFF_W(OFF_W)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .load     (p_load[g]),
            .load_val (sw_load_ptr),
            .adv      (p_adv[g]),
            .adv_cnt  (p_cnt[g]),
            .ring_len (ring_len),
            .ptr      (p_q[g])
        );
    end

    assign wr_ptr = p_q[0];
    assign rd_ptr = p_q[1];

    rbq_level #(.OFF_W(OFF_W)) u_level (
        .clk       (clk),
        .rst       (rst),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .ring_len  (ring_len),
        .valid_cnt (valid_cnt),
        .left_cnt  (left_cnt)
    );

    rbq_irq #(.OFF_W(OFF_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .dir       (dir),
        .valid_cnt (valid_cnt),
        .left_cnt  (left_cnt),
        .thresh    (cfg_thresh),
        .en        (irq_en),
        .clr       (flag_clr),
        .flags     (irq_flags),
        .irq       (irq)
    );

    // R3: a step into a full receive ring leaves the write pointer alone
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cfg_rx && hw_step && (left_cnt == '0)) |=> $stable(wr_ptr));

    // R3: a step out of an empty transmit ring leaves the read pointer alone
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rx && hw_step && (valid_cnt == '0)) |=> $stable(rd_ptr));

    // R11: in receive mode software never moves the write pointer
    a_r11_rx_sw_roles: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rx) && cfg_rx && !$past(hw_step)) |-> $stable(wr_ptr));

endmodule

// File: tb/rbq_ring_monitor_tb_top.sv
module rbq_ring_monitor_tb_top;

    localparam int OFF_W = 16;
    localparam int LOG_W = $clog2(OFF_W + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_rx;
    logic [LOG_W-1:0] cfg_len_log2;
    logic [OFF_W:0]   cfg_thresh;
    logic [1:0]       irq_en;
    logic             sw_load;
    logic [OFF_W:0]   sw_load_ptr;
    logic             sw_adv;
    logic [OFF_W:0]   sw_adv_cnt;
    logic             hw_step;
    logic [1:0]       flag_clr;
    logic [OFF_W:0]   wr_ptr;
    logic [OFF_W:0]   rd_ptr;
    logic [OFF_W:0]   valid_cnt;
    logic [OFF_W:0]   left_cnt;
    logic [1:0]       irq_flags;
    logic             irq;

    always #4 clk = ~clk;

    rbq_ring_monitor #(.OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_rx(cfg_rx), .cfg_len_log2(cfg_len_log2),
        .cfg_thresh(cfg_thresh), .irq_en(irq_en), .sw_load(sw_load),
        .sw_load_ptr(sw_load_ptr), .sw_adv(sw_adv), .sw_adv_cnt(sw_adv_cnt),
        .hw_step(hw_step), .flag_clr(flag_clr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .valid_cnt(valid_cnt), .left_cnt(left_cnt), .irq_flags(irq_flags), .irq(irq)
    );

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    // Reference model: positions count modulo twice the length.
    int  m_len, m_w, m_r, m_thr;
    bit  m_rx;

    function automatic int m_valid();
        return (m_w - m_r + 2 * m_len) % (2 * m_len);
    endfunction

    function automatic logic [OFF_W:0] ptr_of(input int pos);
        logic [OFF_W:0] p;
        p[OFF_W]     = (pos >= m_len);
        p[OFF_W-1:0] = OFF_W'(pos % m_len);
        return p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_counts(input string tag);
        chk({tag, " R4 wr_ptr"}, 32'(wr_ptr), 32'(ptr_of(m_w)));
        chk({tag, " R4 rd_ptr"}, 32'(rd_ptr), 32'(ptr_of(m_r)));
        chk({tag, " R2 valid"}, 32'(valid_cnt), 32'(m_valid()));
        chk({tag, " R2 left"}, 32'(left_cnt), 32'(m_len - m_valid()));
    endtask

    // Clear both flags for one edge, leaving only what the present counts set.
    task automatic settle_flags(input string tag);
        logic e0, e1;
        flag_clr = 2'b11;
        tick();
        flag_clr = 2'b00;
        e0 = m_rx ? (m_valid() >= m_thr) : ((m_len - m_valid()) >= m_thr);
        e1 = m_rx && (m_valid() == m_len);
        chk({tag, " R7 level flag"}, 32'(irq_flags[0]), 32'(e0));
        chk({tag, " R8 full flag"}, 32'(irq_flags[1]), 32'(e1));
        chk({tag, " R10 irq"}, 32'(irq), 32'((e0 & irq_en[0]) | (e1 & irq_en[1])));
    endtask

    task automatic op_hw(input string tag);
        int v;
        v = m_valid();
        hw_step = 1'b1;
        tick();
        hw_step = 1'b0;
        if (m_rx) begin
            if (m_len - v > 0) m_w = (m_w + 1) % (2 * m_len);   // R11 hw moves write
        end else begin
            if (v > 0) m_r = (m_r + 1) % (2 * m_len);           // R11 hw moves read
        end
        check_counts(tag);
        settle_flags(tag);
    endtask

    task automatic op_sw(input string tag, input int cnt, input bit with_hw);
        int v, c, avail;
        v = m_valid();
        avail = m_rx ? v : (m_len - v);
        c = (cnt > avail) ? avail : cnt;                          // R5 clamp
        sw_adv = 1'b1;
        sw_adv_cnt = (OFF_W+1)'(cnt);
        hw_step = with_hw;
        tick();
        sw_adv = 1'b0;
        hw_step = 1'b0;
        if (m_rx) begin
            m_r = (m_r + c) % (2 * m_len);
            if (with_hw && (m_len - v > 0)) m_w = (m_w + 1) % (2 * m_len);
        end else begin
            m_w = (m_w + c) % (2 * m_len);
            if (with_hw && v > 0) m_r = (m_r + 1) % (2 * m_len);
        end
        check_counts(tag);
        settle_flags(tag);
    endtask

    task automatic op_load(input string tag, input int pos);
        sw_load = 1'b1;
        sw_load_ptr = ptr_of(pos);
        sw_adv = 1'b1;                 // R6 load wins over advance
        sw_adv_cnt = (OFF_W+1)'(1);
        tick();
        sw_load = 1'b0;
        sw_adv = 1'b0;
        if (m_rx) m_r = pos;
        else      m_w = pos;
        check_counts(tag);
        settle_flags(tag);
    endtask

    task automatic configure(input bit rx, input int k);
        rst = 1'b1;
        cfg_rx = rx;
        cfg_len_log2 = LOG_W'(k);
        m_rx = rx;
        m_len = 1 << k;
        m_thr = rx ? (m_len * 3) / 4 : (m_len * 7) / 8;
        cfg_thresh = (OFF_W+1)'(m_thr);
        irq_en = 2'b11;
        tick();
        tick();
        // R1: reset state, sampled while reset is still held
        chk("R1 wr_ptr", 32'(wr_ptr), 32'd0);
        chk("R1 rd_ptr", 32'(rd_ptr), 32'd0);
        chk("R1 flags", 32'(irq_flags), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 valid", 32'(valid_cnt), 32'd0);
        chk("R1 left", 32'(left_cnt), 32'(m_len));
        rst = 1'b0;
        m_w = 0;
        m_r = 0;
    endtask

    initial begin
        rst = 1'b1; cfg_rx = 1'b0; cfg_len_log2 = '0; cfg_thresh = '0; irq_en = '0;
        sw_load = 1'b0; sw_load_ptr = '0; sw_adv = 1'b0; sw_adv_cnt = '0;
        hw_step = 1'b0; flag_clr = 2'b00;
        @(negedge clk);

        for (int rx = 0; rx < 2; rx++) begin
            for (int k = 3; k >= 2; k--) begin
                configure(rx[0], k);
                settle_flags("after reset");
                // R3: hardware steps past full (rx) or empty (tx) are dropped
                for (int j = 0; j < m_len + 2; j++) op_hw("R3 hw sweep");
                // R5: oversized software advance is clamped
                op_sw("R5 big advance", m_len + 5, 1'b0);
                for (int j = 0; j < m_len + 2; j++) op_hw("R3 hw sweep2");
                // Mixed pattern sweeping every occupancy and the wrap points
                for (int i = 0; i < 4 * m_len + 4; i++) begin
                    irq_en = 2'(i);
                    case (i % 5)
                        0, 1, 4: op_hw("R11 mixed hw");
                        2:       op_sw("R4 mixed sw", i % (m_len + 2), 1'b0);
                        default: op_sw("R5 mixed both", (i % 3) + 1, 1'b1);
                    endcase
                end
                irq_en = 2'b11;
                // R6: load of the software-owned pointer
                if (rx != 0) op_load("R6 load rx", m_w);
                else         op_load("R6 load tx", (m_r + 2) % (2 * m_len));
            end
        end

        // R9 / R10: stickiness, selective clear, set-wins, masking
        configure(1'b1, 3);
        irq_en = 2'b01;
        for (int j = 0; j < 6; j++) op_hw("R9 fill");
        sw_adv = 1'b1; sw_adv_cnt = (OFF_W+1)'(3);
        tick();
        sw_adv = 1'b0;
        m_r = m_r + 3;
        tick();
        chk("R9 sticky flag", 32'(irq_flags[0]), 32'd1);
        chk("R10 irq from sticky", 32'(irq), 32'd1);
        flag_clr = 2'b10;
        tick();
        flag_clr = 2'b00;
        chk("R9 other bit clear", 32'(irq_flags[0]), 32'd1);
        flag_clr = 2'b01;
        tick();
        flag_clr = 2'b00;
        chk("R9 cleared", 32'(irq_flags[0]), 32'd0);
        chk("R10 irq dropped", 32'(irq), 32'd0);
        for (int j = 0; j < 3; j++) op_hw("R9 refill");
        flag_clr = 2'b01;
        tick();
        tick();
        chk("R9 set wins", 32'(irq_flags[0]), 32'd1);
        flag_clr = 2'b00;
        irq_en = 2'b00;
        tick();
        chk("R10 masked", 32'(irq), 32'd0);
        irq_en = 2'b10;
        for (int j = 0; j < 2; j++) op_hw("R8 fill to full");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule